// File: doc/BRIEF.md
# Password-Protected Flash Command Register Set

This block is the software-facing front of an on-chip flash controller. It holds three 16-bit registers on a simple word bus: a mode register that requests erase, single-word programming or block programming, a clock configuration byte, and a status and control register. Every write must carry a fixed password in its upper byte. A write with the wrong password is discarded, flags a key violation and requests a system reset.

Accepted mode writes become one-cycle command pulses to a separate operation engine. The engine reports its progress back on live busy and wait inputs, and an operation-done pulse returns the mode register to idle. Illegal mode or configuration writes are refused while the engine is working. Each refusal sets an access-violation flag, which can raise a non-maskable interrupt request. An emergency-exit bit aborts whatever is in progress and locks the flash again.

Top module: `flash_cmd_regs`

## Requirements
- R1: A write (`bus_we`=1) is acted on only when `bus_word`=1 and `bus_addr` is 0x0128 (mode), 0x012A (clock config) or 0x012C (status). A byte write, or a write to any other address, changes no register, raises no flag and requests no reset.
- R2: An acted-on write whose upper data byte is not 0xA5 leaves the target register unchanged, sets the key-violation flag (status bit 1) and pulses `rst_req` high for the one cycle after the write edge.
- R3: A read of any of the three addresses returns 0x96 in bits 15:8 and the register byte in bits 7:0. Any other address reads as 0x0000.
- R4: The mode byte holds block-write in bit 7, write in bit 6 and erase kind in bits 2:1 (0 none, 1 segment, 2 main area, 3 all). An accepted write that moves the erase kind from 0 to non-zero pulses `cmd_erase`. Setting bit 6 while write is off pulses `cmd_block` and turns on block mode if bit 7 is also 1; otherwise it pulses `cmd_single`. Each pulse is one cycle, in the cycle after the write edge.
- R5: A mode write while the erase kind is non-zero or write is on is refused and sets the access-violation flag (status bit 2). The one exception is block mode with `eng_wait`=1.
- R6: In block mode with `eng_wait`=1, a mode write with bit 7 = 0 pulses `cmd_block_end` and turns block mode off.
- R7: A clock-config write with `eng_busy`=1 is refused and sets the access-violation flag. Otherwise it stores the low byte.
- R8: The status byte reads emergency-exit (bit 5), lock (bit 4), `eng_wait` (bit 3), access violation (bit 2), key violation (bit 1) and `eng_busy` (bit 0). The lock bit written with a valid key drives `flash_locked`.
- R9: Writing status bit 5 as 1 while the stored bit is 0 clears all mode bits, forces `flash_locked` to 1 and pulses `cmd_abort` for one cycle.
- R10: After reset the flash is locked, the mode byte is 0x00, the clock config is 0x42, and the emergency-exit and both violation bits are 0.
- R11: `nmi_req` is high exactly while the access-violation flag is 1 and `viol_irq_en` is 1.
- R12: A valid status write clears a violation flag when that flag's bit is written as 0, and leaves the flag unchanged when the bit is written as 1.
- R13: An `op_done` pulse clears the mode byte, unless an accepted mode write occurs in the same cycle, in which case the write decides the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 16 | Write data; bits 15:8 carry the password |
| bus_we | input | 1 | Write strobe |
| bus_word | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| eng_busy | input | 1 | Engine is running an operation |
| eng_wait | input | 1 | Engine is ready for the next block word |
| op_done | input | 1 | Engine finished; mode returns to idle |
| viol_irq_en | input | 1 | Enable for the access-violation interrupt |
| erase_mode | output | 2 | Current erase kind |
| write_mode | output | 1 | Write mode active |
| block_mode | output | 1 | Block-write mode active |
| cmd_erase | output | 1 | Start-erase pulse |
| cmd_single | output | 1 | Start single-write pulse |
| cmd_block | output | 1 | Start block-write pulse |
| cmd_block_end | output | 1 | End-of-block pulse |
| cmd_abort | output | 1 | Emergency-exit pulse |
| flash_locked | output | 1 | Flash writes locked |
| rst_req | output | 1 | Reset request after a password failure |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
Directed sequences check each rule in isolation. They send a wrong password, a byte access and an unmapped address, which separates the key check from the address and width filters. They issue a mode write with the engine busy, first with wait low and then with wait high, which separates a refused write from the block-mode exception. A second emergency-exit write sent without first clearing the bit shows that only the 0-to-1 change triggers an exit. Random traffic then mixes these patterns. It varies password validity, access width, addresses, busy and wait levels and done pulses, and it compares every readback and command pulse against a bench model. This exposes ordering faults such as a done pulse overriding an accepted write.

// File: rtl/flash_regs_pkg.sv
package flash_regs_pkg;

    localparam logic [15:0] ADDR_MODE   = 16'h0128;
    localparam logic [15:0] ADDR_CLKCFG = 16'h012A;
    localparam logic [15:0] ADDR_STATUS = 16'h012C;
    localparam logic [7:0]  PASS_WR     = 8'hA5;
    localparam logic [7:0]  PASS_RD     = 8'h96;
    localparam logic [7:0]  CLKCFG_RST  = 8'h42;

    // bit positions inside the status byte
    localparam int ST_BUSY = 0;
    localparam int ST_KEYV = 1;
    localparam int ST_ACCV = 2;
    localparam int ST_WAIT = 3;
    localparam int ST_LOCK = 4;
    localparam int ST_EMEX = 5;

    typedef enum logic [1:0] {
        ERS_NONE = 2'd0,
        ERS_SEG  = 2'd1,
        ERS_MAIN = 2'd2,
        ERS_ALL  = 2'd3
    } erase_e;

    typedef struct packed {
        logic   blk;
        logic   wrt;
        erase_e erase;
    } mode_t;

endpackage

// File: rtl/fkr_decode.sv
module fkr_decode
    import flash_regs_pkg::*;
#(
    parameter logic [15:0] A_MODE   = ADDR_MODE,
    parameter logic [15:0] A_CLKCFG = ADDR_CLKCFG,
    parameter logic [15:0] A_STATUS = ADDR_STATUS,
    parameter logic [7:0]  KEY      = PASS_WR
) (
    input  logic [15:0] addr,
    input  logic [7:0]  wdata_hi,
    input  logic        we,
    input  logic        word,
    output logic [2:0]  hit,
    output logic [2:0]  wr_sel,
    output logic        key_bad
);
    localparam int NREG = 3;
    logic [NREG-1:0][15:0] map;
    logic wr_ok;

    assign map = {A_STATUS, A_CLKCFG, A_MODE};

    for (genvar i = 0; i < NREG; i++) begin : g_hit
        assign hit[i] = (addr == map[i]);
    end

    always_comb begin
        wr_ok   = we && word && (|hit);
        key_bad = wr_ok && (wdata_hi != KEY);
        wr_sel  = hit & {NREG{wr_ok && !key_bad}};
    end
endmodule

// File: rtl/fkr_mode.sv
module fkr_mode
    import flash_regs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_mode,
    input  mode_t wr_val,
    input  logic  eng_wait,
    input  logic  op_done,
    input  logic  exit_now,
    output mode_t mode,
    output logic  reject,
    output logic  go_erase,
    output logic  go_single,
    output logic  go_block,
    output logic  go_end
);
    typedef struct packed {
        mode_t m;
        logic  erase;
        logic  single;
        logic  block;
        logic  blk_end;
    } mode_st_t;

    mode_st_t st_q, st_d;
    logic     active, exempt;

    always_comb begin
        active = (st_q.m.erase != ERS_NONE) || st_q.m.wrt;
        exempt = st_q.m.blk && eng_wait;
        reject = wr_mode && active && !exempt;

        st_d         = st_q;
        st_d.erase   = 1'b0;
        st_d.single  = 1'b0;
        st_d.block   = 1'b0;
        st_d.blk_end = 1'b0;

        if (exit_now) begin
            st_d.m = '0;
        end else if (wr_mode && !reject) begin
            if (st_q.m.erase == ERS_NONE && wr_val.erase != ERS_NONE)
                st_d.erase = 1'b1;
            st_d.m.erase = wr_val.erase;
            if (wr_val.wrt && !st_q.m.wrt) begin
                st_d.m.wrt = 1'b1;
                if (wr_val.blk) begin
                    st_d.m.blk = 1'b1;
                    st_d.block = 1'b1;
                end else begin
                    st_d.single = 1'b1;
                end
            end
            if (st_q.m.blk && !wr_val.blk) begin
                st_d.m.blk   = 1'b0;
                st_d.blk_end = 1'b1;
            end
        end else if (op_done) begin
            st_d.m = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode      = st_q.m;
    assign go_erase  = st_q.erase;
    assign go_single = st_q.single;
    assign go_block  = st_q.block;
    assign go_end    = st_q.blk_end;
endmodule

// File: rtl/fkr_status.sv
module fkr_status
    import flash_regs_pkg::*;
#(
    parameter logic [7:0] CFG_RST = CLKCFG_RST
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_cfg,
    input  logic       wr_stat,
    input  logic       key_bad,
    input  logic [7:0] wdata_lo,
    input  logic       eng_busy,
    input  logic       mode_reject,
    output logic [7:0] cfg,
    output logic       lock,
    output logic       emex,
    output logic       accv,
    output logic       keyv,
    output logic       exit_now,
    output logic       rst_req,
    output logic       abort
);
    typedef struct packed {
        logic [7:0] cfg;
        logic       lock;
        logic       emex;
        logic       accv;
        logic       keyv;
        logic       rst_req;
        logic       abort;
    } stat_st_t;

    stat_st_t st_q, st_d;
    logic     cfg_reject;

    always_comb begin
        exit_now   = wr_stat && wdata_lo[ST_EMEX] && !st_q.emex;
        cfg_reject = wr_cfg && eng_busy;

        st_d         = st_q;
        st_d.rst_req = key_bad;
        st_d.abort   = exit_now;

        if (key_bad) st_d.keyv = 1'b1;

        if (wr_cfg && !eng_busy) st_d.cfg = wdata_lo;

        if (wr_stat) begin
            st_d.emex = wdata_lo[ST_EMEX];
            st_d.lock = exit_now ? 1'b1 : wdata_lo[ST_LOCK];
            if (!wdata_lo[ST_KEYV]) st_d.keyv = 1'b0;
            if (!wdata_lo[ST_ACCV]) st_d.accv = 1'b0;
        end

        if (mode_reject || cfg_reject) st_d.accv = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cfg  <= CFG_RST;
            st_q.lock <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg     = st_q.cfg;
    assign lock    = st_q.lock;
    assign emex    = st_q.emex;
    assign accv    = st_q.accv;
    assign keyv    = st_q.keyv;
    assign rst_req = st_q.rst_req;
    assign abort   = st_q.abort;
endmodule

// File: rtl/fkr_readmux.sv
module fkr_readmux
    import flash_regs_pkg::*;
#(
    parameter logic [7:0] TAG = PASS_RD
) (
    input  logic [2:0]  hit,
    input  logic [7:0]  byte_mode,
    input  logic [7:0]  byte_cfg,
    input  logic [7:0]  byte_stat,
    output logic [15:0] rdata
);
    always_comb begin
        unique case (1'b1)
            hit[0]:  rdata = {TAG, byte_mode};
            hit[1]:  rdata = {TAG, byte_cfg};
            hit[2]:  rdata = {TAG, byte_stat};
            default: rdata = 16'h0000;
        endcase
    end
endmodule

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
    import flash_regs_pkg::*;
#(
    parameter logic [15:0] A_MODE   = ADDR_MODE,
    parameter logic [15:0] A_CLKCFG = ADDR_CLKCFG,
    parameter logic [15:0] A_STATUS = ADDR_STATUS,
    parameter logic [7:0]  CFG_RST  = CLKCFG_RST
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_addr,
    input  logic [15:0] bus_wdata,
    input  logic        bus_we,
    input  logic        bus_word,
    output logic [15:0] bus_rdata,
    input  logic        eng_busy,
    input  logic        eng_wait,
    input  logic        op_done,
    input  logic        viol_irq_en,
    output logic [1:0]  erase_mode,
    output logic        write_mode,
    output logic        block_mode,
    output logic        cmd_erase,
    output logic        cmd_single,
    output logic        cmd_block,
    output logic        cmd_block_end,
    output logic        cmd_abort,
    output logic        flash_locked,
    output logic        rst_req,
    output logic        nmi_req
);
    logic [2:0] hit, wr_sel;
    logic       key_bad, reject, exit_now;
    mode_t      wr_val, mode;
    logic [7:0] cfg, byte_mode, byte_stat;
    logic       emex, accv, keyv;

    fkr_decode #(
        .A_MODE(A_MODE), .A_CLKCFG(A_CLKCFG), .A_STATUS(A_STATUS), .KEY(PASS_WR)
    ) u_decode (
        .addr(bus_addr), .wdata_hi(bus_wdata[15:8]), .we(bus_we), .word(bus_word),
        .hit(hit), .wr_sel(wr_sel), .key_bad(key_bad)
    );

    assign wr_val.blk   = bus_wdata[7];
    assign wr_val.wrt   = bus_wdata[6];
    assign wr_val.erase = erase_e'(bus_wdata[2:1]);

    fkr_mode u_mode (
        .clk(clk), .rst_n(rst_n), .wr_mode(wr_sel[0]), .wr_val(wr_val),
        .eng_wait(eng_wait), .op_done(op_done), .exit_now(exit_now),
        .mode(mode), .reject(reject), .go_erase(cmd_erase), .go_single(cmd_single),
        .go_block(cmd_block), .go_end(cmd_block_end)
    );

    fkr_status #(.CFG_RST(CFG_RST)) u_status (
        .clk(clk), .rst_n(rst_n), .wr_cfg(wr_sel[1]), .wr_stat(wr_sel[2]),
        .key_bad(key_bad), .wdata_lo(bus_wdata[7:0]), .eng_busy(eng_busy),
        .mode_reject(reject), .cfg(cfg), .lock(flash_locked), .emex(emex),
        .accv(accv), .keyv(keyv), .exit_now(exit_now), .rst_req(rst_req),
        .abort(cmd_abort)
    );

    assign byte_mode = {mode.blk, mode.wrt, 3'b000, mode.erase, 1'b0};
    assign byte_stat = {2'b00, emex, flash_locked, eng_wait, accv, keyv, eng_busy};

    fkr_readmux #(.TAG(PASS_RD)) u_read (
        .hit(hit), .byte_mode(byte_mode), .byte_cfg(cfg), .byte_stat(byte_stat),
        .rdata(bus_rdata)
    );

    assign erase_mode = mode.erase;
    assign write_mode = mode.wrt;
    assign block_mode = mode.blk;
    assign nmi_req    = accv && viol_irq_en;
endmodule

// File: rtl/fkr_checker.sv
module fkr_checker
    import flash_regs_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] bus_addr,
    input logic [15:0] bus_wdata,
    input logic        bus_we,
    input logic        bus_word,
    input logic [15:0] bus_rdata,
    input logic        viol_irq_en,
    input logic [1:0]  erase_mode,
    input logic        write_mode,
    input logic        block_mode,
    input logic        cmd_single,
    input logic        cmd_block,
    input logic        cmd_block_end,
    input logic        cmd_abort,
    input logic        flash_locked,
    input logic        rst_req,
    input logic        nmi_req
);
    logic mapped;
    assign mapped = (bus_addr == ADDR_MODE) || (bus_addr == ADDR_CLKCFG) ||
                    (bus_addr == ADDR_STATUS);

    p_bad_key_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_word && mapped && bus_wdata[15:8] != PASS_WR) |=> rst_req);

    p_byte_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_word) |=> !rst_req);

    p_read_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mapped |-> bus_rdata[15:8] == PASS_RD);

    p_nmi_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> viol_irq_en);

    p_cmd_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_single, cmd_block, cmd_block_end}));

    p_exit_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_abort |-> (flash_locked && erase_mode == 2'd0 && !write_mode && !block_mode));

    p_block_needs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        block_mode |-> write_mode);
endmodule

bind flash_cmd_regs fkr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_word(bus_word), .bus_rdata(bus_rdata),
    .viol_irq_en(viol_irq_en), .erase_mode(erase_mode), .write_mode(write_mode),
    .block_mode(block_mode), .cmd_single(cmd_single), .cmd_block(cmd_block),
    .cmd_block_end(cmd_block_end), .cmd_abort(cmd_abort),
    .flash_locked(flash_locked), .rst_req(rst_req), .nmi_req(nmi_req)
);

// File: tb/flash_cmd_regs_bench.sv
`timescale 1ns/100ps
module flash_cmd_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0, bus_wdata = '0;
    logic        bus_we = 1'b0, bus_word = 1'b0;
    logic [15:0] bus_rdata;
    logic        eng_busy = 1'b0, eng_wait = 1'b1, op_done = 1'b0, viol_irq_en = 1'b0;
    logic [1:0]  erase_mode;
    logic        write_mode, block_mode, cmd_erase, cmd_single, cmd_block;
    logic        cmd_block_end, cmd_abort, flash_locked, rst_req, nmi_req;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    // bench model state
    logic       m_blk = 0, m_wrt = 0, m_lock = 1, m_emex = 0, m_accv = 0, m_keyv = 0;
    logic [1:0] m_ers = 0;
    logic [7:0] m_cfg = 8'h42;

    always #2 clk = ~clk;

    flash_cmd_regs u_flash_cmd_regs (.*);

    task automatic chk(input string tag, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] rd_exp(input logic [15:0] a);
        case (a)
            16'h0128: rd_exp = {8'h96, m_blk, m_wrt, 3'b000, m_ers, 1'b0};
            16'h012A: rd_exp = {8'h96, m_cfg};
            16'h012C: rd_exp = {8'h96, 2'b00, m_emex, m_lock, eng_wait, m_accv, m_keyv, eng_busy};
            default:  rd_exp = 16'h0000;
        endcase
    endfunction

    task automatic check_all(input string tag);
        logic [15:0] addrs [4] = '{16'h0128, 16'h012A, 16'h012C, 16'h0130};
        foreach (addrs[i]) begin
            bus_addr = addrs[i];
            #0.2;
            chk(tag, "readback", bus_rdata, rd_exp(addrs[i]));
        end
        chk(tag, "erase_mode", {14'd0, erase_mode}, {14'd0, m_ers});
        chk(tag, "write/block", {14'd0, write_mode, block_mode}, {14'd0, m_wrt, m_blk});
        chk(tag, "flash_locked", {15'd0, flash_locked}, {15'd0, m_lock});
        chk(tag, "nmi_req", {15'd0, nmi_req}, {15'd0, m_accv & viol_irq_en});
    endtask

    task automatic step(input string tag, input logic [15:0] a, input logic [15:0] d,
                        input logic word, input logic done, input logic busy,
                        input logic wt, input logic en);
        logic sel, kb, vw, c1, act, rej, ext;
        logic e_ers, e_sgl, e_blk, e_end;
        sel = word && (a == 16'h0128 || a == 16'h012A || a == 16'h012C);
        kb  = sel && (d[15:8] != 8'hA5);
        vw  = sel && !kb;
        c1  = vw && a == 16'h0128;
        act = (m_ers != 0) || m_wrt;
        rej = c1 && act && !(m_blk && wt);
        ext = vw && a == 16'h012C && d[5] && !m_emex;
        {e_ers, e_sgl, e_blk, e_end} = '0;
        if (kb) m_keyv = 1;
        if (ext) begin
            {m_ers, m_wrt, m_blk} = '0;
        end else if (c1 && !rej) begin
            if (m_ers == 0 && d[2:1] != 0) e_ers = 1;
            if (d[6] && !m_wrt) begin
                m_wrt = 1;
                if (d[7]) begin m_blk = 1; e_blk = 1; end else e_sgl = 1;
            end
            if (m_blk && !d[7] && !e_blk) begin m_blk = 0; e_end = 1; end
            m_ers = d[2:1];
        end else if (done) begin
            {m_ers, m_wrt, m_blk} = '0;
        end
        if (vw && a == 16'h012A) begin
            if (busy) m_accv = 1; else m_cfg = d[7:0];
        end
        if (vw && a == 16'h012C) begin
            m_emex = d[5];
            m_lock = ext ? 1'b1 : d[4];
            if (!d[1]) m_keyv = 0;
            if (!d[2]) m_accv = 0;
        end
        if (rej) m_accv = 1;

        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_word = word; bus_we = 1'b1;
        op_done = done; eng_busy = busy; eng_wait = wt; viol_irq_en = en;
        @(posedge clk);
        #0.3;
        bus_we = 1'b0; op_done = 1'b0;
        chk(tag, "rst_req", {15'd0, rst_req}, {15'd0, kb});
        chk(tag, "cmd pulses", {12'd0, cmd_erase, cmd_single, cmd_block, cmd_block_end},
            {12'd0, e_ers, e_sgl, e_blk, e_end});
        chk(tag, "cmd_abort", {15'd0, cmd_abort}, {15'd0, ext});
        check_all(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #0.3;
        check_all("R10");

        // R1: byte write and unmapped writes are ignored
        step("R1", 16'h012A, 16'hA511, 1'b0, 0, 0, 1, 0);
        step("R1", 16'h0130, 16'h1234, 1'b1, 0, 0, 1, 0);
        // R2: wrong password
        step("R2", 16'h012A, 16'h5A77, 1'b1, 0, 0, 1, 0);
        // R12: clear key violation, keep lock
        step("R12", 16'h012C, 16'hA510, 1'b1, 0, 0, 1, 0);
        // R8: unlock
        step("R8", 16'h012C, 16'hA500, 1'b1, 0, 0, 1, 0);
        // R4: single write
        step("R4", 16'h0128, 16'hA540, 1'b1, 0, 1, 0, 1);
        // R5 + R11: refused mode write, interrupt enabled
        step("R5", 16'h0128, 16'hA500, 1'b1, 0, 1, 0, 1);
        step("R11", 16'h0000, 16'h0000, 1'b1, 0, 1, 0, 0);
        // R13: done clears modes
        step("R13", 16'h0000, 16'h0000, 1'b1, 1, 0, 1, 1);
        step("R12", 16'h012C, 16'hA500, 1'b1, 0, 0, 1, 1);
        // R4: erase main area
        step("R4", 16'h0128, 16'hA504, 1'b1, 0, 1, 0, 0);
        // R7: config write while busy, then idle
        step("R7", 16'h012A, 16'hA533, 1'b1, 0, 1, 0, 0);
        step("R13", 16'h0000, 16'h0000, 1'b1, 1, 0, 1, 0);
        step("R7", 16'h012A, 16'hA533, 1'b1, 0, 0, 1, 0);
        // R6: block write, refused without wait, end with wait
        step("R4", 16'h0128, 16'hA5C0, 1'b1, 0, 1, 1, 0);
        step("R5", 16'h0128, 16'hA540, 1'b1, 0, 1, 0, 0);
        step("R6", 16'h0128, 16'hA540, 1'b1, 0, 1, 1, 0);
        step("R13", 16'h0000, 16'h0000, 1'b1, 1, 0, 1, 0);
        // R9: emergency exit during block write, repeat needs 0 first
        step("R9", 16'h0128, 16'hA5C0, 1'b1, 0, 1, 1, 0);
        step("R9", 16'h012C, 16'hA520, 1'b1, 0, 1, 1, 0);
        step("R9", 16'h0128, 16'hA540, 1'b1, 1, 0, 1, 0);
        step("R9", 16'h012C, 16'hA520, 1'b1, 0, 1, 1, 0);
        step("R9", 16'h012C, 16'hA500, 1'b1, 0, 0, 1, 0);
        // R13: done and accepted write in same cycle, write wins
        step("R13", 16'h0128, 16'hA540, 1'b1, 1, 0, 1, 0);

        for (int i = 0; i < 600; i++) begin
            logic [15:0] a, d;
            case ($urandom % 5)
                0: a = 16'h0128;
                1: a = 16'h012A;
                2: a = 16'h012C;
                3: a = 16'h0130;
                default: a = 16'h0129;
            endcase
            d = 16'($urandom);
            if ($urandom % 8 != 0) d[15:8] = 8'hA5;
            step("R3", a, d, ($urandom % 10) != 0, ($urandom % 5) == 0,
                 ($urandom % 3) == 0, ($urandom % 2) == 0, ($urandom % 2) == 0);
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule